// File: doc/BRIEF.md
# Lane-Splittable Wide Add/Logic Unit

This block is the second-stage arithmetic and logic unit of a multiply-accumulate slice. It takes two operands. The first, X, is built by placing a 34-bit `a` field above a 24-bit `b` field. The second, Z, is either the 58-bit `c` input or the 58-bit cascade input that comes from the previous slice's result. A registered 4-bit operation code selects addition, subtraction, XOR or AND. A registered 3-bit carry source code selects the carry-in used by arithmetic. The 58-bit result and four carry flags are captured in an output register, which also drives the cascade outputs to the next slice.

An elaboration parameter sets the width of the carry chain. With `LANES = 1` the adder spans all 58 bits and reports its carry on the top flag only. With `LANES = 4` the carry chain is cut at every 12-bit boundary. Each 12-bit lane then reports its own carry-out, and the top ten bits above bit 47 form an isolated segment whose carry is discarded. The cascade carry output can be chosen as this slice's own next carry-in, so a result can be extended over several cycles.

Top module: `simd_alu`

## Requirements
- R1: X is `{a, b}`, with `a` in bits 57:24 and `b` in bits 23:0. Z is `c` when `z_sel` = 0 and `p_casc_in` when `z_sel` = 1.
- R2: Operation code 4'b0000 adds: the result is Z + X + cin, modulo the width of each segment.
- R3: Operation code 4'b0001 subtracts: the result is Z − X − cin. The carry flag of a segment is 1 when that segment needs no borrow, that is, when Z ≥ X + cin over that segment.
- R4: Operation code 4'b0010 gives X XOR Z and 4'b0011 gives X AND Z. Every other code gives a result of zero. In all of these non-arithmetic cases the four carry flags are zero.
- R5: The carry source code selects cin as follows: 3'd0 selects `carry_in`, 3'd1 selects `carry_casc_in`, and 3'd2 selects this slice's own `carry_casc_out`. Codes 3'd3 to 3'd7 give a cin of 0.
- R6: With `LANES = 1`, `carry_out[3]` is the carry out of bit 57 and `carry_out[2:0]` read as zero.
- R7: With `LANES = 4`, lane k covers bits 12k+11:12k and `carry_out[k]` is that lane's carry. cin enters lane 0 only. Lanes 1 to 3 and bits 57:48 have no carry-in, and no carry crosses any boundary. Bits 57:48 compute Z ± X with their carry dropped.
- R8: The operation code and the carry source code are registered. Each register loads on its own enable (`ce_mode` or `ce_ctrl`) and clears to zero on its own reset (`rst_mode` or `rst_ctrl`) or on `rst`. A newly loaded code first affects the result captured at the following clock edge.
- R9: The result register and the carry flags load only when `ce_p` = 1. They clear to zero on `rst_p` or `rst`, and reset has priority over the enable. After reset every output reads zero.
- R10: `p_casc_out` always equals `p`, and `carry_casc_out` always equals `carry_out[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of every register |
| a | input | 34 | Upper field of operand X |
| b | input | 24 | Lower field of operand X |
| c | input | 58 | Direct Z operand |
| p_casc_in | input | 58 | Result cascaded from the previous slice |
| z_sel | input | 1 | Z source: 0 = c, 1 = p_casc_in |
| alu_mode | input | 4 | Operation code |
| ce_mode | input | 1 | Load enable of the operation code register |
| rst_mode | input | 1 | Reset of the operation code register |
| carry_sel | input | 3 | Carry source code |
| ce_ctrl | input | 1 | Load enable of the carry source register |
| rst_ctrl | input | 1 | Reset of the carry source register |
| carry_in | input | 1 | Carry from fabric logic |
| carry_casc_in | input | 1 | Carry cascaded from the previous slice |
| ce_p | input | 1 | Load enable of the result register |
| rst_p | input | 1 | Reset of the result register |
| p | output | 58 | Registered result |
| p_casc_out | output | 58 | Result cascaded to the next slice |
| carry_out | output | 4 | Registered carry flags, one per lane |
| carry_casc_out | output | 1 | Top carry flag, cascaded to the next slice |

## Verification
The bench builds two instances that share every input. One has `LANES = 4` and the other `LANES = 1`, so the same operands show both a split carry chain and a full 58-bit carry chain. Operands of all-ones lanes plus one expose any carry that leaks from one 12-bit lane into the next in the split build. The same operands show that carry rippling to the top flag in the full-width build. Because the carry feedback depends on each instance's own top flag, the two instances also walk through different multi-cycle carry histories.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int unsigned OP_W  = 4;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned CO_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_XOR = 4'd2,
        OP_AND = 4'd3
    } alu_op_e;

    typedef enum logic [SEL_W-1:0] {
        CIN_FABRIC = 3'd0,
        CIN_CASC   = 3'd1,
        CIN_LOOP   = 3'd2
    } cin_src_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] csel;
    } ctrl_t;

    function automatic logic op_is_arith(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_is_sub(input logic [OP_W-1:0] op);
        return op == OP_SUB;
    endfunction

endpackage

// File: rtl/simd_alu_ctrl_regs.sv
module simd_alu_ctrl_regs
    import simd_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  mode_d,
    input  logic             ce_mode,
    input  logic             rst_mode,
    input  logic [SEL_W-1:0] csel_d,
    input  logic             ce_ctrl,
    input  logic             rst_ctrl,
    output ctrl_t            ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst || rst_mode) begin
            ctrl_q.op <= '0;
        end else if (ce_mode) begin
            ctrl_q.op <= mode_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rst_ctrl) begin
            ctrl_q.csel <= '0;
        end else if (ce_ctrl) begin
            ctrl_q.csel <= csel_d;
        end
    end

endmodule

// File: rtl/simd_alu_carry_mux.sv
module simd_alu_carry_mux
    import simd_alu_pkg::*;
(
    input  logic [SEL_W-1:0] csel,
    input  logic             cin_fabric,
    input  logic             cin_casc,
    input  logic             cin_loop,
    output logic             cin
);

    always_comb begin
        case (csel)
            CIN_FABRIC: cin = cin_fabric;
            CIN_CASC:   cin = cin_casc;
            CIN_LOOP:   cin = cin_loop;
            default:    cin = 1'b0;
        endcase
    end

endmodule

// File: rtl/simd_alu_core.sv
module simd_alu_core
    import simd_alu_pkg::*;
#(
    parameter int unsigned DW     = 58,
    parameter int unsigned LANE_W = 12,
    parameter int unsigned LANES  = 4
) (
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   z,
    input  logic [OP_W-1:0] op,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic [CO_W-1:0] co
);

    localparam int unsigned SPAN  = (LANES == 1) ? DW : LANE_W * LANES;
    localparam int unsigned EXT_W = DW - SPAN;

    logic            sub;
    logic [DW-1:0]   xm;
    logic            ci_low;
    logic [DW-1:0]   sum;
    logic [CO_W-1:0] co_arith;

    assign sub    = op_is_sub(op);
    assign xm     = sub ? ~x : x;
    assign ci_low = sub ? ~cin : cin;

    generate
        if (LANES == 1) begin : g_full
            logic [DW:0] tot;
            assign tot      = {1'b0, z} + {1'b0, xm} + (DW+1)'(ci_low);
            assign sum      = tot[DW-1:0];
            assign co_arith = {tot[DW], {(CO_W-1){1'b0}}};
        end else begin : g_split
            logic [LANES-1:0] lane_co;
            for (genvar g = 0; g < LANES; g++) begin : g_lane
                logic          ci_g;
                logic [LANE_W:0] t;
                if (g == 0) begin : g_first
                    assign ci_g = ci_low;
                end else begin : g_rest
                    assign ci_g = sub;
                end
                assign t = {1'b0, z[g*LANE_W +: LANE_W]}
                         + {1'b0, xm[g*LANE_W +: LANE_W]}
                         + (LANE_W+1)'(ci_g);
                assign sum[g*LANE_W +: LANE_W] = t[LANE_W-1:0];
                assign lane_co[g] = t[LANE_W];
            end
            if (EXT_W > 0) begin : g_ext
                assign sum[DW-1:SPAN] = z[DW-1:SPAN] + xm[DW-1:SPAN] + EXT_W'(sub);
            end
            assign co_arith = CO_W'(lane_co);
        end
    endgenerate

    always_comb begin
        res = '0;
        co  = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                res = sum;
                co  = co_arith;
            end
            OP_XOR:  res = x ^ z;
            OP_AND:  res = x & z;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int unsigned A_W    = 34,
    parameter int unsigned B_W    = 24,
    parameter int unsigned LANE_W = 12,
    parameter int unsigned LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [A_W-1:0]       a,
    input  logic [B_W-1:0]       b,
    input  logic [A_W+B_W-1:0]   c,
    input  logic [A_W+B_W-1:0]   p_casc_in,
    input  logic                 z_sel,
    input  logic [OP_W-1:0]      alu_mode,
    input  logic                 ce_mode,
    input  logic                 rst_mode,
    input  logic [SEL_W-1:0]     carry_sel,
    input  logic                 ce_ctrl,
    input  logic                 rst_ctrl,
    input  logic                 carry_in,
    input  logic                 carry_casc_in,
    input  logic                 ce_p,
    input  logic                 rst_p,
    output logic [A_W+B_W-1:0]   p,
    output logic [A_W+B_W-1:0]   p_casc_out,
    output logic [CO_W-1:0]      carry_out,
    output logic                 carry_casc_out
);

    localparam int unsigned DW = A_W + B_W;

    ctrl_t           ctrl_q;
    logic [DW-1:0]   x_op;
    logic [DW-1:0]   z_op;
    logic            cin;
    logic [DW-1:0]   res;
    logic [CO_W-1:0] co;
    logic [DW-1:0]   p_q;
    logic [CO_W-1:0] co_q;

    assign x_op = {a, b};
    assign z_op = z_sel ? p_casc_in : c;

    simd_alu_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_d   (alu_mode),
        .ce_mode  (ce_mode),
        .rst_mode (rst_mode),
        .csel_d   (carry_sel),
        .ce_ctrl  (ce_ctrl),
        .rst_ctrl (rst_ctrl),
        .ctrl_q   (ctrl_q)
    );

    simd_alu_carry_mux u_cmux (
        .csel       (ctrl_q.csel),
        .cin_fabric (carry_in),
        .cin_casc   (carry_casc_in),
        .cin_loop   (co_q[CO_W-1]),
        .cin        (cin)
    );

    simd_alu_core #(
        .DW     (DW),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_core (
        .x   (x_op),
        .z   (z_op),
        .op  (ctrl_q.op),
        .cin (cin),
        .res (res),
        .co  (co)
    );

    always_ff @(posedge clk) begin
        if (rst || rst_p) begin
            p_q  <= '0;
            co_q <= '0;
        end else if (ce_p) begin
            p_q  <= res;
            co_q <= co;
        end
    end

    assign p              = p_q;
    assign p_casc_out     = p_q;
    assign carry_out      = co_q;
    assign carry_casc_out = co_q[CO_W-1];

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_alu_pkg::*;
#(
    parameter int unsigned DW = 58
) (
    input logic            clk,
    input logic            rst,
    input logic            ce_mode,
    input logic            rst_mode,
    input logic            ce_ctrl,
    input logic            rst_ctrl,
    input logic            ce_p,
    input logic            rst_p,
    input ctrl_t           ctrl_q,
    input logic [DW-1:0]   x_op,
    input logic [DW-1:0]   z_op,
    input logic            cin,
    input logic [DW-1:0]   p,
    input logic [CO_W-1:0] carry_out,
    input logic            carry_casc_out
);

    p_mode_rst_r8: assert property (@(posedge clk) disable iff (rst)
        rst_mode |=> ctrl_q.op == '0);

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!ce_mode && !rst_mode) |=> $stable(ctrl_q.op));

    p_csel_rst_r8: assert property (@(posedge clk) disable iff (rst)
        rst_ctrl |=> ctrl_q.csel == '0);

    p_csel_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!ce_ctrl && !rst_ctrl) |=> $stable(ctrl_q.csel));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ce_p && !rst_p) |=> ($stable(p) && $stable(carry_out)));

    p_result_clear_r9: assert property (@(posedge clk) disable iff (rst)
        rst_p |=> (p == '0 && carry_out == '0));

    p_logic_nocarry_r4: assert property (@(posedge clk) disable iff (rst)
        (ce_p && !rst_p && !op_is_arith(ctrl_q.op)) |=> carry_out == '0);

    p_and_result_r4: assert property (@(posedge clk) disable iff (rst)
        (ce_p && !rst_p && ctrl_q.op == OP_AND) |=> p == ($past(x_op) & $past(z_op)));

    p_reserved_cin_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.csel > CIN_LOOP) |-> cin == 1'b0);

    p_loop_cin_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.csel == CIN_LOOP) |-> cin == carry_casc_out);

endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ce_mode        (ce_mode),
    .rst_mode       (rst_mode),
    .ce_ctrl        (ce_ctrl),
    .rst_ctrl       (rst_ctrl),
    .ce_p           (ce_p),
    .rst_p          (rst_p),
    .ctrl_q         (ctrl_q),
    .x_op           (x_op),
    .z_op           (z_op),
    .cin            (cin),
    .p              (p),
    .carry_out      (carry_out),
    .carry_casc_out (carry_casc_out)
);

// File: tb/simd_alu_test.sv
module simd_alu_test;

    logic        clk = 1'b0;
    logic        rst, z_sel, ce_mode, rst_mode, ce_ctrl, rst_ctrl;
    logic        carry_in, carry_casc_in, ce_p, rst_p;
    logic [33:0] a;
    logic [23:0] b;
    logic [57:0] c, p_casc_in;
    logic [3:0]  alu_mode;
    logic [2:0]  carry_sel;

    logic [57:0] p4, pc4, p1, pc1;
    logic [3:0]  co4, co1;
    logic        cc4, cc1;

    int n_chk  = 0;
    int n_fail = 0;
    string req = "R9";

    // model state: index 0 = four-lane build, index 1 = full-width build
    logic [57:0] m_p [2];
    logic [3:0]  m_co [2];
    logic [3:0]  m_mode;
    logic [2:0]  m_csel;
    logic [57:0] n_p [2];
    logic [3:0]  n_co [2];
    logic [3:0]  n_mode;
    logic [2:0]  n_csel;

    always #5 clk = ~clk;

    simd_alu #(.LANES(4)) uut (
        .clk(clk), .rst(rst), .a(a), .b(b), .c(c), .p_casc_in(p_casc_in),
        .z_sel(z_sel), .alu_mode(alu_mode), .ce_mode(ce_mode), .rst_mode(rst_mode),
        .carry_sel(carry_sel), .ce_ctrl(ce_ctrl), .rst_ctrl(rst_ctrl),
        .carry_in(carry_in), .carry_casc_in(carry_casc_in), .ce_p(ce_p), .rst_p(rst_p),
        .p(p4), .p_casc_out(pc4), .carry_out(co4), .carry_casc_out(cc4)
    );

    simd_alu #(.LANES(1)) uut_full (
        .clk(clk), .rst(rst), .a(a), .b(b), .c(c), .p_casc_in(p_casc_in),
        .z_sel(z_sel), .alu_mode(alu_mode), .ce_mode(ce_mode), .rst_mode(rst_mode),
        .carry_sel(carry_sel), .ce_ctrl(ce_ctrl), .rst_ctrl(rst_ctrl),
        .carry_in(carry_in), .carry_casc_in(carry_casc_in), .ce_p(ce_p), .rst_p(rst_p),
        .p(p1), .p_casc_out(pc1), .carry_out(co1), .carry_casc_out(cc1)
    );

    function automatic logic [61:0] model(input int lanes, input logic [3:0] m,
                                          input logic [57:0] x, input logic [57:0] z,
                                          input logic ci);
        logic [57:0] r = '0;
        logic [3:0]  f = '0;
        logic [58:0] wide;
        int unsigned zl, xl, cc, s;
        if (m == 4'd0 || m == 4'd1) begin
            if (lanes == 1) begin
                if (m == 4'd0) begin
                    wide = {1'b0, z} + {1'b0, x} + 59'(ci);
                    r = wide[57:0];
                    f[3] = wide[58];
                end else begin
                    r = z - x - 58'(ci);
                    f[3] = ({1'b0, z} >= ({1'b0, x} + 59'(ci)));
                end
            end else begin
                for (int i = 0; i < 4; i++) begin
                    zl = z[i*12 +: 12];
                    xl = x[i*12 +: 12];
                    cc = (i == 0) ? 32'(ci) : 0;
                    if (m == 4'd0) begin
                        s = zl + xl + cc;
                        f[i] = (s > 4095);
                    end else begin
                        s = zl - xl - cc;
                        f[i] = (zl >= xl + cc);
                    end
                    r[i*12 +: 12] = s[11:0];
                end
                r[57:48] = (m == 4'd0) ? z[57:48] + x[57:48] : z[57:48] - x[57:48];
            end
        end else if (m == 4'd2) begin
            r = x ^ z;
        end else if (m == 4'd3) begin
            r = x & z;
        end
        return {f, r};
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // inputs already set at the falling edge; compute model, clock, compare
    task automatic tick();
        logic [57:0] x, z;
        logic [61:0] r;
        logic ci;
        x = {a, b};
        z = z_sel ? p_casc_in : c;
        for (int k = 0; k < 2; k++) begin
            case (m_csel)
                3'd0:    ci = carry_in;
                3'd1:    ci = carry_casc_in;
                3'd2:    ci = m_co[k][3];
                default: ci = 1'b0;
            endcase
            r = model(k == 0 ? 4 : 1, m_mode, x, z, ci);
            if (rst || rst_p) begin
                n_p[k] = '0; n_co[k] = '0;
            end else if (ce_p) begin
                n_p[k] = r[57:0]; n_co[k] = r[61:58];
            end else begin
                n_p[k] = m_p[k]; n_co[k] = m_co[k];
            end
        end
        n_mode = (rst || rst_mode) ? 4'd0 : (ce_mode ? alu_mode : m_mode);
        n_csel = (rst || rst_ctrl) ? 3'd0 : (ce_ctrl ? carry_sel : m_csel);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            m_p[k] = n_p[k]; m_co[k] = n_co[k];
        end
        m_mode = n_mode;
        m_csel = n_csel;
        check("lane4 p/carry", {2'b0, co4, p4}, {2'b0, m_co[0], m_p[0]});
        check("full p/carry",  {2'b0, co1, p1}, {2'b0, m_co[1], m_p[1]});
        // R10: cascade outputs mirror the result register
        check("cascade out R10", {4'b0, cc4, cc1, pc4}, {4'b0, m_co[0][3], m_co[1][3], m_p[0]});
        check("cascade full R10", {6'b0, pc1}, {6'b0, m_p[1]});
    endtask

    task automatic set_ctrl(input logic [3:0] m, input logic [2:0] cs);
        alu_mode = m; carry_sel = cs; ce_mode = 1'b1; ce_ctrl = 1'b1;
        tick();
        ce_mode = 1'b0; ce_ctrl = 1'b0;
    endtask

    task automatic rnd_ops();
        a = 34'({$urandom(), $urandom()});
        b = 24'($urandom());
        c = 58'({$urandom(), $urandom()});
        p_casc_in = 58'({$urandom(), $urandom()});
        carry_in = 1'($urandom());
        carry_casc_in = 1'($urandom());
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_p[k] = '0; m_co[k] = '0;
        end
        m_mode = '0; m_csel = '0;
        rst = 1'b1; z_sel = 0; ce_mode = 0; rst_mode = 0; ce_ctrl = 0; rst_ctrl = 0;
        carry_in = 0; carry_casc_in = 0; ce_p = 1; rst_p = 0;
        a = '1; b = '1; c = '1; p_casc_in = '1; alu_mode = 4'd3; carry_sel = 3'd2;
        @(negedge clk);
        req = "R9"; // reset state
        tick(); tick();
        rst = 1'b0;

        req = "R2";
        set_ctrl(4'd0, 3'd0);
        for (int i = 0; i < 20; i++) begin rnd_ops(); tick(); end
        a = '1; b = '1; c = 58'd1; carry_in = 1'b1; tick();

        req = "R3";
        set_ctrl(4'd1, 3'd0);
        for (int i = 0; i < 20; i++) begin rnd_ops(); tick(); end
        req = "R6";
        a = '0; b = 24'd1; c = '0; carry_in = 0; tick();
        a = '0; b = 24'd5; c = 58'd5; carry_in = 1; tick();
        a = '0; b = 24'd5; c = 58'd5; carry_in = 0; tick();

        req = "R4";
        set_ctrl(4'd2, 3'd0);
        for (int i = 0; i < 6; i++) begin rnd_ops(); tick(); end
        set_ctrl(4'd3, 3'd0);
        for (int i = 0; i < 6; i++) begin rnd_ops(); tick(); end
        set_ctrl(4'd7, 3'd0);
        for (int i = 0; i < 4; i++) begin rnd_ops(); tick(); end
        set_ctrl(4'd15, 3'd0);
        rnd_ops(); tick();

        req = "R1";
        set_ctrl(4'd0, 3'd0);
        z_sel = 1'b1;
        for (int i = 0; i < 8; i++) begin rnd_ops(); tick(); end
        z_sel = 1'b0;

        req = "R5";
        for (int s = 1; s < 8; s++) begin
            set_ctrl(4'd0, 3'(s));
            for (int i = 0; i < 6; i++) begin rnd_ops(); tick(); end
        end
        set_ctrl(4'd0, 3'd2);
        a = '1; b = '1; c = '1; tick(); tick(); tick();

        req = "R7";
        set_ctrl(4'd0, 3'd0);
        a = 34'h000FFFFFF; b = 24'hFFFFFF; c = 58'h0001001001001; carry_in = 0; tick();
        carry_in = 1; tick();
        a = 34'h3FFFFFFFF; c = 58'h3FF001001001001; tick();
        set_ctrl(4'd1, 3'd0);
        a = '0; b = 24'd1; c = '0; carry_in = 0; tick();
        a = 34'h000001001; b = 24'h001001; c = '0; carry_in = 1; tick();

        req = "R8";
        alu_mode = 4'd2; carry_sel = 3'd1;
        for (int i = 0; i < 4; i++) begin rnd_ops(); tick(); end
        rst_mode = 1'b1; ce_mode = 1'b1; rnd_ops(); tick();
        rst_mode = 1'b0; ce_mode = 1'b0; rnd_ops(); tick();
        set_ctrl(4'd1, 3'd1);
        rst_ctrl = 1'b1; rnd_ops(); tick();
        rst_ctrl = 1'b0; for (int i = 0; i < 3; i++) begin rnd_ops(); tick(); end

        req = "R9";
        ce_p = 1'b0;
        for (int i = 0; i < 4; i++) begin rnd_ops(); tick(); end
        rst_p = 1'b1; ce_p = 1'b1; rnd_ops(); tick();
        rst_p = 1'b0; rnd_ops(); tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule